// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block collects single-cycle event pulses from the surrounding logic into two 8-bit interrupt status registers. The events are a sequencer group (high and low FIFO alert, idle, transmit done, receive done, error summary, start-of-frame seen), a low-power detect pulse and five timer underflow pulses. Each flag stays set until software clears it. Two enable registers decide which flags take part in one global interrupt. The global interrupt then drives an interrupt pin. Software chooses whether the pin is gated on, its polarity, and whether it drives push-pull or open-drain.

Software reaches the block through a plain register port: an address, write data, a write strobe, and read data that follows the address in the same cycle. A status write does not store its data. Bit 7 of the data chooses whether the other one-bits set their flags or clear them. This lets one write raise or drop any group of flags and leave the rest alone.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, every flag and enable bit is 0. The global interrupt is 0. Both irq_pin_o and irq_oe_o are 0.
- R2: A write to address 0 (status A) or address 1 (status B) with data bit 7 = 1 sets each flag whose data bit is 1. All other flags keep their value. The change is visible from the cycle after the write.
- R3: The same write with data bit 7 = 0 clears each flag whose data bit is 1. All other flags keep their value.
- R4: An event pulse sets its flag in the next cycle. Status A bits 6..0 are high-alert, low-alert, idle, tx, rx, error and start-of-frame, taken from evt_seq_i[6:0]. Status B bit 5 is low-power detect. Status B bit n (n = 0..4) is the underflow of timer n.
- R5: If an event pulse and a software clear hit the same flag in the same cycle, the flag is set afterwards.
- R6: Status B bit 6 reads the global interrupt. The global interrupt is the OR of every flag ANDed with its enable bit: enable A bits 6..0 for status A, enable B bits 5..0 for status B. Software cannot set or clear it through a write. Bit 7 of both status registers reads 0.
- R7: Enable A (address 2) and enable B (address 3) read back the full byte last written to them.
- R8: When enable B bit 6 is 0, the pin shows the inactive state whatever the global interrupt is.
- R9: Enable A bit 7 = 1 inverts the pin level. The level is (global AND enable B bit 6) XOR enable A bit 7.
- R10: When enable B bit 7 = 1 (push-pull), irq_pin_o equals the level and irq_oe_o is 1. When it is 0 (open-drain), irq_pin_o is 0 and irq_oe_o equals the level, so the pad pulls low only when the level is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for bus_addr |
| evt_seq_i | input | 7 | Sequencer event pulses for status A bits 6..0 |
| evt_lpd_i | input | 1 | Low-power detect pulse |
| evt_tmr_i | input | 5 | Timer underflow pulses, bit n for timer n |
| irq_global_o | output | 1 | Global interrupt |
| irq_pin_o | output | 1 | Pin data value |
| irq_oe_o | output | 1 | Pin output enable |

## Verification
The hardest case to reach is an event pulse that lands in the same cycle as a software clear of the same flag. This needs a bus write and a hardware pulse timed to the same edge. The bench drives them together in one cycle, first as a directed case and then many more times in a random phase where writes and sparse event pulses overlap often. The pin logic is checked in all four combinations of polarity and drive mode, with the pin gate both on and off.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  parameter int unsigned REG_W   = 8;
  parameter int unsigned ADDR_W  = 2;
  parameter int unsigned SEQ_W   = 7;
  parameter int unsigned NUM_TMR = 5;
  localparam int unsigned AUXW   = NUM_TMR + 1;
  localparam int unsigned SEL_BIT = REG_W - 1;
  localparam int unsigned GLB_BIT = REG_W - 2;
  localparam int unsigned PP_BIT  = REG_W - 1;
  localparam int unsigned GATE_BIT = REG_W - 2;
  localparam int unsigned INV_BIT = REG_W - 1;

  typedef enum logic [ADDR_W-1:0] {
    RA_STAT_A = 2'd0,
    RA_STAT_B = 2'd1,
    RA_EN_A   = 2'd2,
    RA_EN_B   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         set_sel,
  input  logic [W-1:0] wbits,
  input  logic [W-1:0] evt,
  output logic [W-1:0] flags_q
);
  logic [W-1:0] flags_d;

  // software write first, hardware event overrides it
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign flags_d[i] = evt[i] | ((wr_en & wbits[i]) ? set_sel : flags_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
  input  logic glb,
  input  logic gate_en,
  input  logic invert,
  input  logic push_pull,
  output logic pin_o,
  output logic oe_o
);
  logic level;

  always_comb begin
    level = (glb & gate_en) ^ invert;
    if (push_pull) begin
      pin_o = level;
      oe_o  = 1'b1;
    end else begin
      pin_o = 1'b0;
      oe_o  = level;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [SEQ_W-1:0]  evt_seq_i,
  input  logic              evt_lpd_i,
  input  logic [NUM_TMR-1:0] evt_tmr_i,
  output logic              irq_global_o,
  output logic              irq_pin_o,
  output logic              irq_oe_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             wr_a, wr_b, wr_en_a, wr_en_b;
  logic [SEQ_W-1:0] flag_a_q;
  logic [AUXW-1:0]  flag_b_q;
  logic [AUXW-1:0]  evt_b;
  logic [REG_W-1:0] en_a_q, en_a_d, en_b_q, en_b_d;
  logic             glb;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  always_comb begin
    wr_a    = bus_we && (bus_addr == RA_STAT_A);
    wr_b    = bus_we && (bus_addr == RA_STAT_B);
    wr_en_a = bus_we && (bus_addr == RA_EN_A);
    wr_en_b = bus_we && (bus_addr == RA_EN_B);
    evt_b   = {evt_lpd_i, evt_tmr_i};
  end

  irq_flag_bank #(.W(SEQ_W)) u_bank_a (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_a),
    .set_sel (bus_wdata[SEL_BIT]),
    .wbits   (bus_wdata[SEQ_W-1:0]),
    .evt     (evt_seq_i),
    .flags_q (flag_a_q)
  );

  irq_flag_bank #(.W(AUXW)) u_bank_b (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_b),
    .set_sel (bus_wdata[SEL_BIT]),
    .wbits   (bus_wdata[AUXW-1:0]),
    .evt     (evt_b),
    .flags_q (flag_b_q)
  );

  // enable registers: next state, then storage
  always_comb begin
    en_a_d = wr_en_a ? bus_wdata : en_a_q;
    en_b_d = wr_en_b ? bus_wdata : en_b_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_a_q <= '0;
      en_b_q <= '0;
    end else begin
      en_a_q <= en_a_d;
      en_b_q <= en_b_d;
    end
  end

  always_comb begin
    glb = (|(flag_a_q & en_a_q[SEQ_W-1:0])) | (|(flag_b_q & en_b_q[AUXW-1:0]));
  end
  assign irq_global_o = glb;

  irq_pin_drv u_pin (
    .glb       (glb),
    .gate_en   (en_b_q[GATE_BIT]),
    .invert    (en_a_q[INV_BIT]),
    .push_pull (en_b_q[PP_BIT]),
    .pin_o     (irq_pin_o),
    .oe_o      (irq_oe_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_STAT_A: bus_rdata[SEQ_W-1:0] = flag_a_q;
      RA_STAT_B: begin
        bus_rdata[AUXW-1:0] = flag_b_q;
        bus_rdata[GLB_BIT]  = glb;
      end
      RA_EN_A:   bus_rdata = en_a_q;
      default:   bus_rdata = en_b_q;
    endcase
  end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [REG_W-1:0]   bus_wdata,
  input logic               bus_we,
  input logic [SEQ_W-1:0]   evt_seq_i,
  input logic [SEQ_W-1:0]   flag_a_q,
  input logic [REG_W-1:0]   en_a_q,
  input logic [REG_W-1:0]   en_b_q,
  input logic               irq_global_o,
  input logic               irq_pin_o,
  input logic               irq_oe_o
);
  // R4 R5: a pulsed sequencer event is always set one cycle later
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_seq_i) |=> ((flag_a_q & $past(evt_seq_i)) == $past(evt_seq_i)));

  // R3: a clear write without a colliding event empties the chosen flags
  a_r3_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RA_STAT_A && !bus_wdata[SEL_BIT])
      |=> ((flag_a_q & $past(bus_wdata[SEQ_W-1:0] & ~evt_seq_i)) == '0));

  // R6: with no enable bit the global interrupt stays low
  a_r6_no_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_q[SEQ_W-1:0] == '0 && en_b_q[AUXW-1:0] == '0) |-> !irq_global_o);

  // R8: gate off in push-pull leaves only the polarity on the pin
  a_r8_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_b_q[GATE_BIT] && en_b_q[PP_BIT]) |-> (irq_pin_o == en_a_q[INV_BIT]));

  // R10: open-drain never drives high, push-pull always drives
  a_r10_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
    !en_b_q[PP_BIT] |-> !irq_pin_o);
  a_r10_pp_drives: assert property (@(posedge clk) disable iff (!rst_n)
    en_b_q[PP_BIT] |-> irq_oe_o);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_we       (bus_we),
  .evt_seq_i    (evt_seq_i),
  .flag_a_q     (flag_a_q),
  .en_a_q       (en_a_q),
  .en_b_q       (en_b_q),
  .irq_global_o (irq_global_o),
  .irq_pin_o    (irq_pin_o),
  .irq_oe_o     (irq_oe_o)
);

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
  logic       clk;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we;
  logic [7:0] bus_rdata;
  logic [6:0] evt_seq_i;
  logic       evt_lpd_i;
  logic [4:0] evt_tmr_i;
  logic       irq_global_o, irq_pin_o, irq_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  logic [6:0] m_a;
  logic [5:0] m_b;
  logic [7:0] m_ea, m_eb;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .evt_seq_i(evt_seq_i),
    .evt_lpd_i(evt_lpd_i), .evt_tmr_i(evt_tmr_i), .irq_global_o(irq_global_o),
    .irq_pin_o(irq_pin_o), .irq_oe_o(irq_oe_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_ea = 0; m_eb = 0;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          2'd0: m_a = bus_wdata[7] ? (m_a | bus_wdata[6:0]) : (m_a & ~bus_wdata[6:0]);
          2'd1: m_b = bus_wdata[7] ? (m_b | bus_wdata[5:0]) : (m_b & ~bus_wdata[5:0]);
          2'd2: m_ea = bus_wdata;
          default: m_eb = bus_wdata;
        endcase
      end
      m_a = m_a | evt_seq_i;
      m_b = m_b | {evt_lpd_i, evt_tmr_i};
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic g, lvl;
    logic [7:0] rd;
    string t;
    g   = (|(m_a & m_ea[6:0])) | (|(m_b & m_eb[5:0]));
    lvl = (g & m_eb[6]) ^ m_ea[7];
    case (bus_addr)
      2'd0: begin rd = {1'b0, m_a}; t = "R2 R3 R4 R5 status A"; end
      2'd1: begin rd = {1'b0, g, m_b}; t = "R2 R3 R4 R5 R6 status B"; end
      2'd2: begin rd = m_ea; t = "R7 enable A"; end
      default: begin rd = m_eb; t = "R7 enable B"; end
    endcase
    check(t, bus_rdata, rd);
    check("R6 global", {7'd0, irq_global_o}, {7'd0, g});
    check("R8 R9 R10 pin", {7'd0, irq_pin_o}, {7'd0, m_eb[7] ? lvl : 1'b0});
    check("R10 oe", {7'd0, irq_oe_o}, {7'd0, m_eb[7] ? 1'b1 : lvl});
  endtask

  task automatic step(input logic [1:0] a, input logic [7:0] d, input logic we,
                      input logic [6:0] es, input logic lp, input logic [4:0] et);
    @(negedge clk);
    compare_all();
    bus_addr = a; bus_wdata = d; bus_we = we;
    evt_seq_i = es; evt_lpd_i = lp; evt_tmr_i = et;
  endtask

  task automatic rd(input logic [1:0] a);
    step(a, 8'h00, 1'b0, 7'd0, 1'b0, 5'd0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(a, d, 1'b1, 7'd0, 1'b0, 5'd0);
  endtask

  initial begin
    rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_we = 0;
    evt_seq_i = 0; evt_lpd_i = 0; evt_tmr_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    // R1: reset state seen through every register and the pin
    for (int a = 0; a < 4; a++) begin
      bus_addr = a[1:0];
      @(negedge clk);
      check("R1 reset read", bus_rdata, 8'h00);
    end
    check("R1 reset pin", {6'd0, irq_pin_o, irq_oe_o}, 8'h00);
    check("R1 reset global", {7'd0, irq_global_o}, 8'h00);

    // R7 enables
    wr(2, 8'h5A); wr(3, 8'h25); rd(2); rd(3);
    wr(2, 8'h00); wr(3, 8'h00);
    // R2 set, R3 clear on status A; R6 bit 7 reads zero
    wr(0, 8'hFF); rd(0); wr(0, 8'h05); rd(0); wr(0, 8'h7F); rd(0);
    // R2 R3 status B; writing the global bit does nothing (R6)
    wr(1, 8'hC0); rd(1); wr(1, 8'hA1); rd(1); wr(1, 8'h3F); rd(1);
    // R4 each event individually
    for (int i = 0; i < 7; i++) begin
      step(0, 0, 0, 7'(1 << i), 0, 0); rd(0); wr(0, 8'h7F);
    end
    for (int i = 0; i < 5; i++) begin
      step(1, 0, 0, 0, 0, 5'(1 << i)); rd(1); wr(1, 8'h3F);
    end
    step(1, 0, 0, 0, 1, 0); rd(1);
    // R5 event and clear in the same cycle
    wr(0, 8'hFF);
    step(0, 8'h7F, 1, 7'h10, 0, 0); rd(0);
    step(1, 8'h3F, 1, 0, 1, 5'h04); rd(1);
    // R6 R8 R9 R10 pin combinations
    for (int m = 0; m < 8; m++) begin
      wr(2, {m[0], 7'h10});
      wr(3, {m[2], m[1], 6'h00});
      rd(1); rd(0);
      wr(0, 8'h00); rd(1);
      wr(0, 8'h90); rd(1);
      wr(0, 8'h10); rd(1);
    end
    // random phase: overlapping writes and events
    for (int k = 0; k < 600; k++) begin
      logic [6:0] es; logic lp; logic [4:0] et;
      es = ($urandom % 4 == 0) ? 7'($urandom) : 7'd0;
      lp = ($urandom % 6 == 0);
      et = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
      step(2'($urandom), 8'($urandom), ($urandom % 2) == 1, es, lp, et);
    end
    rd(0);
    rd(1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule